// File: doc/BRIEF.md
# Cascaded One-Hot Address Decoder

This block turns a binary address into a one-hot, active-low select bus. It is built from identical 3-bit slices, each with eight outputs. Each slice is gated by three enable terminals of mixed polarity: one active-high and two active-low. A slice drives exactly one output low when all three enables agree. When they do not agree, every output of that slice stays high. A bus that is entirely high therefore means that no decode is in progress.

In the default 4-bit build there are two slices. The address bit above the three shared select bits is steered into opposite-polarity enables of the two slices. It disables the lower slice and enables the upper one, so the two halves of the bus never decode together. An external active-low enable reaches the remaining enable terminals and can force the whole bus high. A user that does not need it ties it low.

Setting the address width to 5 gives four slices. The extra address bit goes to the chip-select terminals, and each slice then serves one quarter of the 32-output bus. The block is purely combinational: the outputs follow the inputs without any clock.

Top module: `casc_onehot_dec`

## Requirements
- R1: While `en_n` is 0, output `out_n[i]` is 0 for the index i that equals `addr` read as an unsigned number.
- R2: While `en_n` is 0, exactly one bit of `out_n` is 0 and every other bit is 1.
- R3: While `en_n` is 1, every bit of `out_n` is 1 for any value of `addr`.
- R4: Bit 3 of `addr` chooses the 8-output group. When it is 0, only `out_n[7:0]` can hold a 0. When it is 1, only `out_n[15:8]` can hold a 0. The unselected group stays entirely 1.
- R5: With `en_n` = 0 and `addr` = 4'b1100, `out_n` equals 16'hEFFF, so output 12 is the one driven low.
- R6: When `ADDR_W` = 5, `addr[4]` joins the chip-select logic. All 32 codes decode one-hot onto a 32-bit `out_n`, and `en_n` = 1 still forces all 32 bits to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | ADDR_W (4) | Binary code to decode. The low 3 bits feed every slice; the upper bits pick the slice. |
| en_n | input | 1 | Active-low enable for the whole bus. Tie it to 0 when it is not used. |
| out_n | output | 2**ADDR_W (16) | One-hot, active-low select bus. All ones means no decode. |

## Verification
The group handoff and the global disable can both happen in the same cycle. The bench provokes this by changing `addr` across the 0111/1000 boundary on the same edge as it toggles `en_n`, in both directions. Each result is judged against the full expected bus: all ones while disabled, and exactly the one addressed bit low in the new group while enabled. A stale low bit left in the old group, or a missed disable, therefore shows up directly.

// File: rtl/casc_dec_pkg.sv
package casc_dec_pkg;
  localparam int unsigned SLICE_W   = 3;
  localparam int unsigned SLICE_OUT = 1 << SLICE_W;

  typedef struct packed {
    logic act_hi;   // active-high enable terminal
    logic act_lo_a; // first active-low enable terminal
    logic act_lo_b; // second active-low enable terminal
  } slice_en_t;

  function automatic logic slice_open(input slice_en_t e);
    return e.act_hi & ~e.act_lo_a & ~e.act_lo_b;
  endfunction
endpackage

// File: rtl/oct_slice.sv
module oct_slice
  import casc_dec_pkg::*;
#(
  parameter int unsigned SEL_W = SLICE_W,
  localparam int unsigned N_OUT = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  input  slice_en_t        en,
  output logic [N_OUT-1:0] out_n
);
  logic open_q;
  assign open_q = slice_open(en);

  for (genvar i = 0; i < N_OUT; i++) begin : g_line
    assign out_n[i] = ~(open_q & (sel == SEL_W'(i)));
  end
endmodule

// File: rtl/slice_steer.sv
module slice_steer
  import casc_dec_pkg::*;
#(
  parameter int unsigned UP_W = 1,
  localparam int unsigned N_SL = 1 << UP_W
) (
  input  logic [UP_W-1:0] up,
  input  logic            en_n,
  output slice_en_t       en_vec [N_SL]
);
  // Bit 0 of the upper field is steered into opposite-polarity terminals.
  // The remaining upper bits act as chip-select, merged with the global enable.
  for (genvar k = 0; k < N_SL; k++) begin : g_sl
    logic gate_n;
    if (UP_W == 1) begin : g_flat
      assign gate_n = en_n;
    end else begin : g_cs
      assign gate_n = en_n | (up[UP_W-1:1] != (UP_W-1)'(k >> 1));
    end

    if ((k % 2) == 0) begin : g_even
      assign en_vec[k].act_hi   = 1'b1;
      assign en_vec[k].act_lo_a = up[0];
      assign en_vec[k].act_lo_b = gate_n;
    end else begin : g_odd
      assign en_vec[k].act_hi   = up[0];
      assign en_vec[k].act_lo_a = gate_n;
      assign en_vec[k].act_lo_b = gate_n;
    end
  end
endmodule

// File: rtl/casc_onehot_dec.sv
module casc_onehot_dec
  import casc_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned UP_W  = ADDR_W - SLICE_W,
  localparam int unsigned N_SL  = 1 << UP_W,
  localparam int unsigned OUT_W = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_n,
  output logic [OUT_W-1:0]  out_n
);
  slice_en_t en_vec [N_SL];

  slice_steer #(.UP_W(UP_W)) u_steer (
    .up     (addr[ADDR_W-1:SLICE_W]),
    .en_n   (en_n),
    .en_vec (en_vec)
  );

  for (genvar k = 0; k < N_SL; k++) begin : g_slice
    oct_slice #(.SEL_W(SLICE_W)) u_slice (
      .sel   (addr[SLICE_W-1:0]),
      .en    (en_vec[k]),
      .out_n (out_n[k*SLICE_OUT +: SLICE_OUT])
    );
  end
endmodule

// File: rtl/casc_onehot_dec_chk.sv
module casc_onehot_dec_chk
  import casc_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned OUT_W = 1 << ADDR_W
) (
  input logic [ADDR_W-1:0] addr,
  input logic              en_n,
  input logic [OUT_W-1:0]  out_n
);
  logic [OUT_W-1:0]     hot;
  logic [SLICE_OUT-1:0] grp;

  always_comb begin
    hot = ~out_n;
    grp = SLICE_OUT'(hot >> (int'(addr[ADDR_W-1:SLICE_W]) * SLICE_OUT));
    if (!en_n) begin
      assert_addr_low_R1: assert (out_n[addr] == 1'b0)
        else $error("addressed line not low");
      assert_single_low_R2: assert ($countones(hot) == 1)
        else $error("not exactly one line low");
      assert_group_only_R4: assert (grp != '0)
        else $error("low line outside selected group");
    end else begin
      assert_disabled_high_R3: assert (&out_n)
        else $error("line low while disabled");
    end
    if (ADDR_W == 4 && !en_n && addr == ADDR_W'(12)) begin
      assert_code12_R5: assert (out_n == OUT_W'(16'hEFFF))
        else $error("code 1100 mismatch");
    end
  end
endmodule

bind casc_onehot_dec casc_onehot_dec_chk #(.ADDR_W(ADDR_W)) u_chk (
  .addr  (addr),
  .en_n  (en_n),
  .out_n (out_n)
);

// File: tb/casc_onehot_dec_tb.sv
module casc_onehot_dec_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk; // 200 MHz

  logic [3:0]  addr   = '0;
  logic        en_n   = 1'b1;
  logic [15:0] out_n;
  logic [4:0]  addr5  = '0;
  logic        en5_n  = 1'b1;
  logic [31:0] out5_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  casc_onehot_dec #(.ADDR_W(4)) u_dut (.addr(addr), .en_n(en_n), .out_n(out_n));
  casc_onehot_dec #(.ADDR_W(5)) u_dut_w5 (.addr(addr5), .en_n(en5_n), .out_n(out5_n));

  // {en_n, addr, expected out_n}
  localparam logic [20:0] VEC [10] = '{
    {1'b0, 4'hC, 16'hEFFF},  // R5
    {1'b0, 4'h0, 16'hFFFE},  // R1
    {1'b0, 4'h7, 16'hFF7F},  // R4 top of low group
    {1'b0, 4'h8, 16'hFEFF},  // R4 bottom of high group
    {1'b0, 4'hF, 16'h7FFF},  // R1
    {1'b0, 4'h3, 16'hFFF7},  // R2
    {1'b1, 4'hC, 16'hFFFF},  // R3
    {1'b1, 4'h0, 16'hFFFF},  // R3
    {1'b1, 4'hF, 16'hFFFF},  // R3
    {1'b0, 4'h5, 16'hFFDF}   // R1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive4(input logic e, input logic [3:0] a);
    @(posedge clk);
    en_n = e;
    addr = a;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // idle (reset) state: inputs parked disabled
    @(negedge clk);
    chk("R3 idle", {16'h0, out_n}, 32'h0000FFFF);

    // table walk
    for (int i = 0; i < 10; i++) begin
      drive4(VEC[i][20], VEC[i][19:16]);
      chk("R1/R3/R5 table", {16'h0, out_n}, {16'h0, VEC[i][15:0]});
    end

    // full sweep, both enable states
    for (int e = 0; e < 2; e++) begin
      for (int a = 0; a < 16; a++) begin
        logic [15:0] exp;
        exp = (e == 1) ? 16'hFFFF : ~(16'h1 << a);
        drive4(e[0], a[3:0]);
        chk("R2 sweep", {16'h0, out_n}, {16'h0, exp});
        if (e == 0) begin
          if (a < 8) chk("R4 high group idle", {24'h0, out_n[15:8]}, 32'hFF);
          else       chk("R4 low group idle", {24'h0, out_n[7:0]}, 32'hFF);
        end
      end
    end

    // group handoff coinciding with enable toggles
    drive4(1'b0, 4'h7);
    chk("R4 pre-handoff", {16'h0, out_n}, 32'h0000FF7F);
    drive4(1'b1, 4'h8);
    chk("R3 handoff+disable", {16'h0, out_n}, 32'h0000FFFF);
    drive4(1'b0, 4'h7);
    chk("R4 handoff+enable down", {16'h0, out_n}, 32'h0000FF7F);
    drive4(1'b0, 4'h8);
    chk("R4 handoff up", {16'h0, out_n}, 32'h0000FEFF);
    drive4(1'b1, 4'h7);
    chk("R3 handoff down+disable", {16'h0, out_n}, 32'h0000FFFF);
    drive4(1'b0, 4'hC);
    chk("R5 enable with 1100", {16'h0, out_n}, 32'h0000EFFF);

    // 5-bit variant
    for (int e = 0; e < 2; e++) begin
      for (int a = 0; a < 32; a++) begin
        logic [31:0] exp;
        exp = (e == 1) ? 32'hFFFF_FFFF : ~(32'h1 << a);
        @(posedge clk);
        en5_n = e[0];
        addr5 = a[4:0];
        @(negedge clk);
        chk("R6 wide sweep", out5_n, exp);
      end
    end

    finish_run();
  end
endmodule